// File: doc/BRIEF.md
# Alarm Match Flag Unit

This block watches a calendar time supplied to it as BCD digits (minute, hour, day of month, day of week) and raises an alarm when that time matches a programmed alarm pattern. Four alarm registers hold the pattern. Bit 7 of each register is a field enable with inverted sense: the field joins the comparison only while that bit is 0, and it is skipped while the bit is 1. The comparison is sampled only in the cycle where the external timekeeper pulses its update strobe.

The alarm flag is sticky. It is raised only on a transition from "no match" to "match" between two successive time updates, and it stays raised until software writes 0 to it. The active-low interrupt output follows the flag, gated by an interrupt enable bit. Software reaches the alarm registers and the control bits through a simple write-strobe and combinational-read register port.

The flag is held by a two-state machine. ST_CLEAR moves to ST_RAISED on a rising match at an update strobe. ST_RAISED returns to ST_CLEAR when software writes 0 to the flag bit and no rising match arrives in the same cycle. Otherwise each state holds.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, register addresses 1 to 4 read 0x80, address 0 reads 0x00 and irq_no is 1, so the alarm is disabled.
- R2: Address 0 is the control register: bit 0 is the interrupt enable, bit 1 is the alarm flag, and the other bits read 0. Addresses 1, 2, 3 and 4 hold the minute, hour, date and weekday alarm registers, which are written and read back as full bytes. Addresses 5 to 7 read 0x00, and writes to them change no register.
- R3: An enabled field compares only its value bits against the matching time input: minute bits 6:0, hour bits 5:0, date bits 5:0 and weekday bits 2:0. Bits outside these ranges, on either the alarm register or the time input, are ignored.
- R4: A field whose alarm register has bit 7 set to 1 takes no part in the comparison.
- R5: When all four alarm registers have bit 7 set to 1, the flag never sets.
- R6: The flag sets on a clock edge where tick_i is 1, every enabled field matches, and the previous update did not match. It reads as 1 from the following cycle.
- R7: If software clears the flag while the match is still present, a later update with the same matching time does not set the flag again. The flag sets again only after an update that does not match is followed by one that does.
- R8: The flag stays at 1 until a write to address 0 with bit 1 equal to 0. A write with bit 1 equal to 1 leaves the flag unchanged.
- R9: irq_no is 0 exactly while the flag and the interrupt enable are both 1. With the enable at 0, the flag still sets but irq_no stays at 1.
- R10: Writing alarm values that match the current time does not set the flag. The flag sets at the next update strobe.
- R11: If a clearing write to address 0 and a flag-setting update occur in the same cycle, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time update strobe; the comparison is sampled in this cycle |
| min_i | input | 8 | Current minute, BCD |
| hour_i | input | 8 | Current hour, BCD |
| date_i | input | 8 | Current day of month, BCD |
| wday_i | input | 8 | Current day of week, 0 to 6 |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_no | output | 1 | Alarm interrupt, active low |

## Verification
The most telling internal fault is a wrong remembered match from the previous update. If that history is lost, the flag is raised again on the first update after software clears it, so a fault shows one strobe after the clearing write. If the history sticks at "matched", the flag never rises again, and the fault shows at the next genuine match. A fault in the enable sense or in a field mask shows at the first update strobe that uses the field, as a flag and irq_no that disagree with the programmed pattern in the cycle after that strobe. The checks sample both irq_no and the control register in that cycle.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

    parameter int DATA_W   = 8;
    parameter int ADDR_W   = 3;
    parameter int N_FIELDS = 4;

    // Bit positions and reset values shared by the register port.
    localparam int EN_BIT   = 7;
    localparam int IE_BIT   = 0;
    localparam int FLAG_BIT = 1;
    localparam logic [DATA_W-1:0] FIELD_RST = DATA_W'(1) << EN_BIT;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    // Compare masks, one byte per field: minute, hour, date, weekday.
    localparam logic [N_FIELDS*DATA_W-1:0] FIELD_MASKS = {8'h07, 8'h3F, 8'h3F, 8'h7F};

    typedef enum logic {
        ST_CLEAR  = 1'b0,
        ST_RAISED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_match_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NF = N_FIELDS
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            flag_i,
    output logic [DW-1:0]   rdata_o,
    output logic [NF*DW-1:0] alarm_o,
    output logic            ie_o,
    output logic            clr_o
);

    logic ie_q;
    logic ctrl_sel;

    assign ctrl_sel = (addr_i == AW'(CTRL_ADDR));
    assign clr_o    = wr_i && ctrl_sel && !wdata_i[FLAG_BIT];
    assign ie_o     = ie_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            ie_q <= 1'b0;
        else if (wr_i && ctrl_sel)
            ie_q <= wdata_i[IE_BIT];
    end

    for (genvar g = 0; g < NF; g++) begin : g_field
        localparam logic [AW-1:0] MY_ADDR = AW'(g + 1);
        logic [DW-1:0] val_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
                val_q <= DW'(FIELD_RST);
            else if (wr_i && addr_i == MY_ADDR)
                val_q <= wdata_i;
        end

        assign alarm_o[g*DW +: DW] = val_q;
    end

    always_comb begin
        rdata_o = '0;
        if (ctrl_sel) begin
            rdata_o[IE_BIT]   = ie_q;
            rdata_o[FLAG_BIT] = flag_i;
        end
        for (int i = 0; i < NF; i++) begin
            if (addr_i == AW'(i + 1))
                rdata_o = alarm_o[i*DW +: DW];
        end
    end

    // R2
    alarm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(alarm_o));

    // R2
    ie_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(ie_o));

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
    import alarm_match_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NF = N_FIELDS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NF*DW-1:0]  alarm_i,
    input  logic [NF*DW-1:0]  time_i,
    output logic              match_o
);

    logic [NF-1:0] hit;
    logic [NF-1:0] used;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        logic [DW-1:0] a;
        logic [DW-1:0] t;
        logic [DW-1:0] m;
        assign a       = alarm_i[g*DW +: DW];
        assign t       = time_i[g*DW +: DW];
        assign m       = FIELD_MASKS[g*DW +: DW];
        assign used[g] = !a[EN_BIT];
        assign hit[g]  = !used[g] || (((a ^ t) & m) == '0);
    end

    assign match_o = (&hit) && (|used);

    // R5
    all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(used) == 0) |-> !match_o);

endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_match_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic match_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q, state_d;
    logic        prev_q;
    logic        rise;

    assign rise = tick_i && match_i && !prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_CLEAR;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tick_i)
                prev_q <= match_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:  if (rise) state_d = ST_RAISED;
            ST_RAISED: if (clr_i && !rise) state_d = ST_CLEAR;
            default:   state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == ST_RAISED);
    end

    // R6
    set_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> $past(tick_i && match_i));

    // R7
    set_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> !$past(prev_q));

    // R8
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !clr_i) |=> flag_o);

    // R6
    no_tick_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flag_o && !tick_i) |=> !flag_o);

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_match_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        tick_i,
    input  logic [7:0]  min_i,
    input  logic [7:0]  hour_i,
    input  logic [7:0]  date_i,
    input  logic [7:0]  wday_i,
    input  logic        wr_i,
    input  logic [2:0]  addr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic        irq_no
);

    localparam int VEC_W = N_FIELDS * DATA_W;

    logic [VEC_W-1:0] alarm_vec;
    logic [VEC_W-1:0] time_vec;
    logic             ie;
    logic             clr;
    logic             flag;
    logic             match;

    assign time_vec = {wday_i, date_i, hour_i, min_i};

    alarm_regs #(.DW(DATA_W), .AW(ADDR_W), .NF(N_FIELDS)) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .flag_i  (flag),
        .rdata_o (rdata_o),
        .alarm_o (alarm_vec),
        .ie_o    (ie),
        .clr_o   (clr)
    );

    alarm_compare #(.DW(DATA_W), .NF(N_FIELDS)) cmp_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .alarm_i (alarm_vec),
        .time_i  (time_vec),
        .match_o (match)
    );

    alarm_flag_fsm fsm_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .match_i (match),
        .clr_i   (clr),
        .flag_o  (flag)
    );

    assign irq_no = !(flag && ie);

    // R9
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ie |-> irq_no);

endmodule

// File: tb/alarm_match_unit_tb_top.sv
module alarm_match_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] tmin = '0, thour = '0, tdate = '0, twday = '0;
    logic       wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alarm_match_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .min_i(tmin), .hour_i(thour), .date_i(tdate), .wday_i(twday),
        .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_no(irq_n)
    );

    // {alarm min,hour,date,wday, time min,hour,date,wday, expected flag}
    localparam logic [64:0] VEC [9] = '{
        {8'h30, 8'h12, 8'h15, 8'h03, 8'h30, 8'h12, 8'h15, 8'h03, 1'b1},
        {8'h30, 8'h12, 8'h15, 8'h03, 8'h31, 8'h12, 8'h15, 8'h03, 1'b0},
        {8'hB0, 8'h12, 8'h15, 8'h03, 8'h31, 8'h12, 8'h15, 8'h03, 1'b1},
        {8'hB0, 8'h92, 8'h95, 8'h83, 8'h30, 8'h12, 8'h15, 8'h03, 1'b0},
        {8'h80, 8'h23, 8'h80, 8'h80, 8'h44, 8'h23, 8'h09, 8'h01, 1'b1},
        {8'h80, 8'h80, 8'h80, 8'h06, 8'h00, 8'h00, 8'h01, 8'h05, 1'b0},
        {8'h80, 8'h52, 8'h80, 8'h80, 8'h00, 8'h12, 8'h01, 8'h00, 1'b1},
        {8'h80, 8'h80, 8'h31, 8'h00, 8'h11, 8'h22, 8'h31, 8'h00, 1'b1},
        {8'h30, 8'h80, 8'h80, 8'h80, 8'hB0, 8'h00, 8'h01, 8'h00, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_tick(input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] dt, input logic [7:0] w);
        @(negedge clk);
        tmin = m; thour = h; tdate = dt; twday = w; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic prime();
        do_tick(8'h7F, 8'h3F, 8'h3F, 8'h07);
    endtask

    task automatic expect_ctrl(input logic [7:0] exp, input string req);
        logic [7:0] d;
        rd_reg(3'd0, d);
        check(d == exp, req, d, exp);
        check(irq_n == !(exp[0] && exp[1]), req, irq_n, !(exp[0] && exp[1]));
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(irq_n == 1'b1, "R1", irq_n, 1);
        rd_reg(3'd0, d); check(d == 8'h00, "R1", d, 8'h00);
        for (int i = 1; i <= 4; i++) begin
            rd_reg(3'(i), d); check(d == 8'h80, "R1", d, 8'h80);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R3 R4 R5 R6 R9
        for (int v = 0; v < 9; v++) begin
            wr_reg(3'd1, VEC[v][64:57]);
            wr_reg(3'd2, VEC[v][56:49]);
            wr_reg(3'd3, VEC[v][48:41]);
            wr_reg(3'd4, VEC[v][40:33]);
            prime();
            wr_reg(3'd0, 8'h01);
            do_tick(VEC[v][32:25], VEC[v][24:17], VEC[v][16:9], VEC[v][8:1]);
            expect_ctrl(VEC[v][0] ? 8'h03 : 8'h01, "R3/R4/R5/R6");
        end

        // R2 read back and unused addresses
        wr_reg(3'd1, 8'h10); wr_reg(3'd2, 8'h05); wr_reg(3'd3, 8'h07); wr_reg(3'd4, 8'h02);
        rd_reg(3'd2, d); check(d == 8'h05, "R2", d, 8'h05);
        wr_reg(3'd6, 8'hFF);
        rd_reg(3'd6, d); check(d == 8'h00, "R2", d, 8'h00);
        rd_reg(3'd5, d); check(d == 8'h00, "R2", d, 8'h00);
        rd_reg(3'd4, d); check(d == 8'h02, "R2", d, 8'h02);

        // R6 set, R7 no re-set on continuing match
        prime();
        wr_reg(3'd0, 8'h01);
        do_tick(8'h10, 8'h05, 8'h07, 8'h02);
        expect_ctrl(8'h03, "R6");
        wr_reg(3'd0, 8'h01);
        expect_ctrl(8'h01, "R8");
        do_tick(8'h10, 8'h05, 8'h07, 8'h02);
        expect_ctrl(8'h01, "R7");
        do_tick(8'h11, 8'h05, 8'h07, 8'h02);
        expect_ctrl(8'h01, "R7");
        do_tick(8'h10, 8'h05, 8'h07, 8'h02);
        expect_ctrl(8'h03, "R7");

        // R8 write 1 keeps the flag, write 0 clears it
        wr_reg(3'd0, 8'h03);
        expect_ctrl(8'h03, "R8");
        wr_reg(3'd0, 8'h01);
        expect_ctrl(8'h01, "R8");

        // R9 enable off: flag sets, irq stays high
        wr_reg(3'd0, 8'h00);
        prime();
        do_tick(8'h10, 8'h05, 8'h07, 8'h02);
        expect_ctrl(8'h02, "R9");
        wr_reg(3'd0, 8'h03);
        expect_ctrl(8'h03, "R9");

        // R10 a write that creates a match waits for the next update
        wr_reg(3'd0, 8'h01);
        prime();
        wr_reg(3'd1, 8'h7F); wr_reg(3'd2, 8'h3F); wr_reg(3'd3, 8'h3F); wr_reg(3'd4, 8'h07);
        repeat (3) @(negedge clk);
        expect_ctrl(8'h01, "R10");
        prime();
        expect_ctrl(8'h03, "R10");

        // R11 clear and set in the same cycle
        do_tick(8'h00, 8'h00, 8'h00, 8'h00);
        wr_reg(3'd0, 8'h01);
        expect_ctrl(8'h01, "R11");
        @(negedge clk);
        tmin = 8'h7F; thour = 8'h3F; tdate = 8'h3F; twday = 8'h07;
        tick = 1'b1; wr = 1'b1; addr = 3'd0; wdata = 8'h01;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0;
        expect_ctrl(8'h03, "R11");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule